// File: doc/BRIEF.md
# Vector Operand Modifier ALU

This block is one execution slice of a programmable shading processor. It works on four-lane vectors kept in a small register file. Each lane is a 32-bit signed fixed-point number in Q16.16, so a register is 128 bits. An instruction names up to three source registers and one destination register. Before the operation, each source can be reordered lane by lane, made absolute and negated, and each of these choices is made separately for that source. The slice then runs one of six vector operations. It writes the result back only to the destination lanes that the instruction enables.

A host loads registers through a dedicated write port and observes them through a combinational read port. The slice takes one instruction per cycle. The result lands in the register file at the clock edge that ends the issue cycle, so the very next instruction can read it. The same edge also registers a copy of the result on the writeback outputs.

Top module: `vec_alu`

## Requirements
- R1: After reset, all sixteen registers read as zero and `wb_valid` is low.
- R2: When `ld_valid` is high and no instruction writes back in that cycle, all 128 bits of `ld_data` land in register `ld_addr` at that clock edge. `rd_data` shows register `rd_addr` combinationally.
- R3: Each source has an 8-bit swizzle. Result lane k takes source lane `swz[2k+1:2k]` (0=x, 1=y, 2=z, 3=w). Lane x sits at bits 31:0, y at 63:32, z at 95:64 and w at 127:96. The identity swizzle is 8'hE4.
- R4: The modifiers are applied in a fixed order: swizzle, then absolute value, then negate. Negation is two's complement. The absolute value of 32'h80000000 stays 32'h80000000.
- R5: Opcode 0 (MOV) copies the modified src0. Opcode 1 (ADD) adds src0 and src1 lane by lane, wrapping modulo 2^32.
- R6: Opcode 2 (MUL) multiplies lane by lane. It keeps bits 47:16 of the full signed 64-bit product, which rounds toward minus infinity and wraps on overflow.
- R7: Opcode 3 (MAD) takes the R6 product of src0 and src1 and adds src2 lane by lane, with wrap-around.
- R8: Opcode 4 (DP4) sums the four R6 lane products with wrap-around and places that sum in every enabled destination lane.
- R9: Opcode 5 (CMP) works on each lane separately. It gives the src1 lane where the src0 lane is >= 0, and the src2 lane otherwise. Zero counts as non-negative.
- R10: `issue_mask[k]` enables destination lane k. A disabled lane keeps its previous value.
- R11: An instruction issued in cycle t updates the register file at the edge that ends cycle t, so an instruction in cycle t+1 reads the new value. After that edge, `wb_valid` is high for one cycle with the destination, the mask and the full unmasked result.
- R12: Opcodes 6 and 7 are undefined. They write nothing and leave `wb_valid` low.
- R13: If a valid instruction writes back in the same cycle as a load, the load is dropped entirely, even when the addresses differ.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| issue_valid | input | 1 | Instruction present this cycle |
| issue_op | input | 3 | Opcode (R5 to R9, R12) |
| issue_dst | input | 4 | Destination register |
| issue_mask | input | 4 | Destination lane enables, bit k = lane k |
| issue_src0 | input | 4 | First source register |
| issue_src1 | input | 4 | Second source register |
| issue_src2 | input | 4 | Third source register |
| issue_swz | input | 24 | Swizzles, source i at bits 8i+7:8i |
| issue_neg | input | 3 | Negate flag, bit i = source i |
| issue_abs | input | 3 | Absolute-value flag, bit i = source i |
| ld_valid | input | 1 | Host load request |
| ld_addr | input | 4 | Host load register |
| ld_data | input | 128 | Host load value |
| rd_addr | input | 4 | Host read register |
| rd_data | output | 128 | Host read value, combinational |
| wb_valid | output | 1 | A result was written at the last edge |
| wb_dst | output | 4 | Register written |
| wb_mask | output | 4 | Lanes written |
| wb_data | output | 128 | Full computed result before masking |

## Verification
Some properties are checked on every cycle:
- a lane with its mask bit clear keeps its value across a writeback;
- an unblocked load lands intact;
- a load that collides with a writeback leaves its target untouched;
- a writeback appears exactly one cycle after a legal issue and never after an undefined one;
- a dot-product result carries one value in all four lanes;
- an absolute-valued operand is never negative except for the most negative code.

The arithmetic itself can only be shown by the directed scenarios. These cover swizzle encodings, the modifier order, product truncation and wrap-around, comparison against zero, and a dependent instruction issued back to back.

// File: rtl/vec_alu_pkg.sv
package vec_alu_pkg;
    localparam int LANES   = 4;
    localparam int LANE_W  = 32;
    localparam int FRAC    = 16;
    localparam int SEL_W   = $clog2(LANES);
    localparam int SWZ_W   = SEL_W * LANES;
    localparam int NSRC    = 3;
    localparam int OP_W    = 3;

    typedef logic [LANE_W-1:0]           lane_t;
    typedef lane_t [LANES-1:0]           vec_t;

    typedef enum logic [OP_W-1:0] {
        OP_MOV = 3'd0,
        OP_ADD = 3'd1,
        OP_MUL = 3'd2,
        OP_MAD = 3'd3,
        OP_DP4 = 3'd4,
        OP_CMP = 3'd5
    } op_e;

    // Fixed-point product: keep the integer-aligned window of the full product
    function automatic lane_t fx_mul(lane_t x, lane_t y);
        logic signed [2*LANE_W-1:0] full;
        full = $signed({{LANE_W{x[LANE_W-1]}}, x}) * $signed({{LANE_W{y[LANE_W-1]}}, y});
        return full[FRAC +: LANE_W];
    endfunction
endpackage

// File: rtl/vec_operand_mod.sv
module vec_operand_mod
    import vec_alu_pkg::*;
(
    input  vec_t               src,
    input  logic [SWZ_W-1:0]   swz,
    input  logic               neg,
    input  logic               absv,
    output vec_t               dout
);
    localparam lane_t MOST_NEG = {1'b1, {(LANE_W-1){1'b0}}};

    for (genvar k = 0; k < LANES; k++) begin : g_lane
        logic [SEL_W-1:0] sel;
        lane_t            picked;
        lane_t            mag;

        always_comb begin
            sel    = swz[k*SEL_W +: SEL_W];
            picked = src[sel];
            mag    = (absv && picked[LANE_W-1]) ? (~picked + 1'b1) : picked;
            dout[k] = neg ? (~mag + 1'b1) : mag;
        end

        // R4: abs without negate never yields a negative lane except the most negative code
        always_comb begin
            if (absv && !neg && picked != MOST_NEG) begin
                p_abs_nonneg_r4: assert (!dout[k][LANE_W-1])
                    else $error("abs operand negative in lane %0d", k);
            end
        end
    end
endmodule

// File: rtl/vec_exec.sv
module vec_exec
    import vec_alu_pkg::*;
(
    input  logic [OP_W-1:0] op,
    input  vec_t            a,
    input  vec_t            b,
    input  vec_t            c,
    output vec_t            res,
    output logic            legal
);
    vec_t  prod;
    lane_t dot;

    for (genvar k = 0; k < LANES; k++) begin : g_mul
        assign prod[k] = fx_mul(a[k], b[k]);
    end

    always_comb begin
        dot = '0;
        for (int k = 0; k < LANES; k++) begin
            dot = dot + prod[k];
        end
    end

    always_comb begin
        legal = 1'b1;
        res   = '0;
        case (op)
            OP_MOV: res = a;
            OP_ADD: for (int k = 0; k < LANES; k++) res[k] = a[k] + b[k];
            OP_MUL: res = prod;
            OP_MAD: for (int k = 0; k < LANES; k++) res[k] = prod[k] + c[k];
            OP_DP4: for (int k = 0; k < LANES; k++) res[k] = dot;
            OP_CMP: for (int k = 0; k < LANES; k++) res[k] = a[k][LANE_W-1] ? c[k] : b[k];
            default: legal = 1'b0;
        endcase
    end
endmodule

// File: rtl/vec_regfile.sv
module vec_regfile
    import vec_alu_pkg::*;
#(
    parameter  int NREGS = 16,
    parameter  int NRD   = NSRC,
    localparam int AW    = $clog2(NREGS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [AW-1:0]    wr_addr,
    input  logic [LANES-1:0] wr_mask,
    input  vec_t             wr_data,
    input  logic             ld_en,
    input  logic [AW-1:0]    ld_addr,
    input  vec_t             ld_data,
    input  logic [AW-1:0]    ra [NRD],
    output vec_t             rdv [NRD],
    input  logic [AW-1:0]    host_addr,
    output vec_t             host_data
);
    vec_t regs_d [NREGS];
    vec_t regs_q [NREGS];

    always_comb begin
        regs_d = regs_q;
        if (wr_en) begin
            for (int k = 0; k < LANES; k++) begin
                if (wr_mask[k]) regs_d[wr_addr][k] = wr_data[k];
            end
        end else if (ld_en) begin
            regs_d[ld_addr] = ld_data;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int r = 0; r < NREGS; r++) regs_q[r] <= '0;
        end else begin
            regs_q <= regs_d;
        end
    end

    for (genvar i = 0; i < NRD; i++) begin : g_rd
        assign rdv[i] = regs_q[ra[i]];
    end
    assign host_data = regs_q[host_addr];

    // R10: disabled lanes of the written register hold their value
    for (genvar k = 0; k < LANES; k++) begin : g_chk
        p_mask_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && !wr_mask[k]) |=> regs_q[$past(wr_addr)][k] == $past(regs_q[wr_addr][k]))
            else $error("masked lane %0d changed", k);
    end

    // R2: an unblocked load lands intact
    p_load_lands_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_en && !wr_en) |=> regs_q[$past(ld_addr)] == $past(ld_data))
        else $error("load did not land");

    // R13: a load colliding with a writeback leaves its target untouched
    p_load_dropped_r13: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_en && wr_en && ld_addr != wr_addr) |=> regs_q[$past(ld_addr)] == $past(regs_q[ld_addr]))
        else $error("colliding load was applied");
endmodule

// File: rtl/vec_alu.sv
module vec_alu
    import vec_alu_pkg::*;
#(
    parameter  int NREGS = 16,
    localparam int AW    = $clog2(NREGS),
    localparam int VW    = LANES * LANE_W
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  issue_valid,
    input  logic [OP_W-1:0]       issue_op,
    input  logic [AW-1:0]         issue_dst,
    input  logic [LANES-1:0]      issue_mask,
    input  logic [AW-1:0]         issue_src0,
    input  logic [AW-1:0]         issue_src1,
    input  logic [AW-1:0]         issue_src2,
    input  logic [NSRC*SWZ_W-1:0] issue_swz,
    input  logic [NSRC-1:0]       issue_neg,
    input  logic [NSRC-1:0]       issue_abs,
    input  logic                  ld_valid,
    input  logic [AW-1:0]         ld_addr,
    input  logic [VW-1:0]         ld_data,
    input  logic [AW-1:0]         rd_addr,
    output logic [VW-1:0]         rd_data,
    output logic                  wb_valid,
    output logic [AW-1:0]         wb_dst,
    output logic [LANES-1:0]      wb_mask,
    output logic [VW-1:0]         wb_data
);
    typedef struct packed {
        logic             valid;
        logic [AW-1:0]    dst;
        logic [LANES-1:0] mask;
        vec_t             data;
    } wb_t;

    logic [AW-1:0] src_addr [NSRC];
    vec_t          src_raw  [NSRC];
    vec_t          src_mod  [NSRC];
    vec_t          result;
    vec_t          host_vec;
    logic          op_ok;
    logic          wr_en;
    wb_t           wb_d, wb_q;

    assign src_addr[0] = issue_src0;
    assign src_addr[1] = issue_src1;
    assign src_addr[2] = issue_src2;

    vec_regfile #(.NREGS(NREGS), .NRD(NSRC)) u_rf (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_addr   (issue_dst),
        .wr_mask   (issue_mask),
        .wr_data   (result),
        .ld_en     (ld_valid),
        .ld_addr   (ld_addr),
        .ld_data   (vec_t'(ld_data)),
        .ra        (src_addr),
        .rdv       (src_raw),
        .host_addr (rd_addr),
        .host_data (host_vec)
    );

    for (genvar i = 0; i < NSRC; i++) begin : g_src
        vec_operand_mod u_mod (
            .src  (src_raw[i]),
            .swz  (issue_swz[i*SWZ_W +: SWZ_W]),
            .neg  (issue_neg[i]),
            .absv (issue_abs[i]),
            .dout (src_mod[i])
        );
    end

    vec_exec u_exec (
        .op    (issue_op),
        .a     (src_mod[0]),
        .b     (src_mod[1]),
        .c     (src_mod[2]),
        .res   (result),
        .legal (op_ok)
    );

    assign wr_en = issue_valid && op_ok;

    always_comb begin
        wb_d       = wb_q;
        wb_d.valid = wr_en;
        if (wr_en) begin
            wb_d.dst  = issue_dst;
            wb_d.mask = issue_mask;
            wb_d.data = result;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) wb_q <= '0;
        else        wb_q <= wb_d;
    end

    assign rd_data  = host_vec;
    assign wb_valid = wb_q.valid;
    assign wb_dst   = wb_q.dst;
    assign wb_mask  = wb_q.mask;
    assign wb_data  = wb_q.data;

    // R11: a legal issue is followed by a writeback strobe one cycle later
    p_wb_follows_issue_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_valid && issue_op <= 3'd5) |=> wb_valid)
        else $error("missing writeback strobe");

    // R12: undefined opcodes and idle cycles produce no writeback
    p_no_wb_undef_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (!issue_valid || issue_op > 3'd5) |=> !wb_valid)
        else $error("spurious writeback strobe");

    // R8: a dot-product result carries one value in every lane
    p_dp4_splat_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_valid && issue_op == 3'd4) |=>
            (wb_data[31:0] == wb_data[63:32] && wb_data[63:32] == wb_data[95:64]
             && wb_data[95:64] == wb_data[127:96]))
        else $error("dot product lanes differ");
endmodule

// File: tb/vec_alu_test.sv
module vec_alu_test;
    localparam int CLK_PERIOD = 10;
    localparam logic [7:0] SW_ID  = 8'hE4;
    localparam logic [7:0] SW_REV = 8'h1B;
    localparam logic [7:0] SW_YYY = 8'h55;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         issue_valid = 1'b0;
    logic [2:0]   issue_op = '0;
    logic [3:0]   issue_dst = '0, issue_mask = '0;
    logic [3:0]   issue_src0 = '0, issue_src1 = '0, issue_src2 = '0;
    logic [23:0]  issue_swz = '0;
    logic [2:0]   issue_neg = '0, issue_abs = '0;
    logic         ld_valid = 1'b0;
    logic [3:0]   ld_addr = '0, rd_addr = '0;
    logic [127:0] ld_data = '0;
    logic [127:0] rd_data, wb_data;
    logic         wb_valid;
    logic [3:0]   wb_dst, wb_mask;

    int checks = 0;
    int errors = 0;
    logic [127:0] model [16];

    always #(CLK_PERIOD/2) clk = ~clk;

    vec_alu uut (
        .clk(clk), .rst_n(rst_n), .issue_valid(issue_valid), .issue_op(issue_op),
        .issue_dst(issue_dst), .issue_mask(issue_mask), .issue_src0(issue_src0),
        .issue_src1(issue_src1), .issue_src2(issue_src2), .issue_swz(issue_swz),
        .issue_neg(issue_neg), .issue_abs(issue_abs), .ld_valid(ld_valid),
        .ld_addr(ld_addr), .ld_data(ld_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .wb_valid(wb_valid), .wb_dst(wb_dst), .wb_mask(wb_mask), .wb_data(wb_data)
    );

    function automatic logic [127:0] v4(logic [31:0] w, logic [31:0] z, logic [31:0] y, logic [31:0] x);
        return {w, z, y, x};
    endfunction

    function automatic logic [31:0] b_mul(logic [31:0] a, logic [31:0] b);
        logic signed [63:0] p;
        p = $signed({{32{a[31]}}, a}) * $signed({{32{b[31]}}, b});
        return p[47:16];
    endfunction

    function automatic logic [127:0] b_mod(logic [127:0] v, logic [7:0] swz, logic n, logic ab);
        logic [127:0] r;
        for (int k = 0; k < 4; k++) begin
            logic [31:0] x;
            x = v[32*swz[2*k +: 2] +: 32];
            if (ab && x[31]) x = -x;
            if (n) x = -x;
            r[32*k +: 32] = x;
        end
        return r;
    endfunction

    function automatic logic [127:0] b_exec(logic [2:0] op, logic [127:0] a, logic [127:0] b, logic [127:0] c);
        logic [127:0] r;
        logic [31:0]  s;
        r = '0;
        s = '0;
        for (int k = 0; k < 4; k++) s = s + b_mul(a[32*k +: 32], b[32*k +: 32]);
        for (int k = 0; k < 4; k++) begin
            logic [31:0] x, y, z;
            x = a[32*k +: 32]; y = b[32*k +: 32]; z = c[32*k +: 32];
            case (op)
                3'd0: r[32*k +: 32] = x;
                3'd1: r[32*k +: 32] = x + y;
                3'd2: r[32*k +: 32] = b_mul(x, y);
                3'd3: r[32*k +: 32] = b_mul(x, y) + z;
                3'd4: r[32*k +: 32] = s;
                3'd5: r[32*k +: 32] = x[31] ? z : y;
                default: r[32*k +: 32] = '0;
            endcase
        end
        return r;
    endfunction

    function automatic logic [127:0] b_merge(logic [127:0] old, logic [127:0] nv, logic [3:0] m);
        logic [127:0] r;
        for (int k = 0; k < 4; k++) r[32*k +: 32] = m[k] ? nv[32*k +: 32] : old[32*k +: 32];
        return r;
    endfunction

    task automatic check128(string tag, logic [127:0] act, logic [127:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic check1(string tag, logic act, logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0b expected=%0b", tag, act, exp);
        end
    endtask

    task automatic read_reg(logic [3:0] a, output logic [127:0] v);
        rd_addr = a;
        #1;
        v = rd_data;
    endtask

    task automatic load(logic [3:0] a, logic [127:0] d);
        @(negedge clk);
        ld_valid = 1'b1; ld_addr = a; ld_data = d;
        @(negedge clk);
        ld_valid = 1'b0;
        model[a] = d;
    endtask

    task automatic drive(logic [2:0] op, logic [3:0] dst, logic [3:0] m,
                         logic [3:0] s0, logic [3:0] s1, logic [3:0] s2,
                         logic [23:0] swz, logic [2:0] n, logic [2:0] ab);
        issue_valid = 1'b1; issue_op = op; issue_dst = dst; issue_mask = m;
        issue_src0 = s0; issue_src1 = s1; issue_src2 = s2;
        issue_swz = swz; issue_neg = n; issue_abs = ab;
    endtask

    // Issue one instruction, predict from the shadow model, check dst and writeback
    task automatic run_op(string tag, logic [2:0] op, logic [3:0] dst, logic [3:0] m,
                          logic [3:0] s0, logic [3:0] s1, logic [3:0] s2,
                          logic [23:0] swz, logic [2:0] n, logic [2:0] ab);
        logic [127:0] a, b, c, res, got;
        logic legal;
        a = b_mod(model[s0], swz[7:0],   n[0], ab[0]);
        b = b_mod(model[s1], swz[15:8],  n[1], ab[1]);
        c = b_mod(model[s2], swz[23:16], n[2], ab[2]);
        res = b_exec(op, a, b, c);
        legal = (op <= 3'd5);
        @(negedge clk);
        drive(op, dst, m, s0, s1, s2, swz, n, ab);
        @(negedge clk);
        issue_valid = 1'b0;
        if (legal) model[dst] = b_merge(model[dst], res, m);
        check1({tag, " wb_valid"}, wb_valid, legal);
        if (legal) check128({tag, " wb_data"}, wb_data, res);
        read_reg(dst, got);
        check128({tag, " dst"}, got, model[dst]);
    endtask

    task automatic t_reset;
        logic [127:0] v;
        for (int r = 0; r < 16; r++) begin
            read_reg(4'(r), v);
            check128("R1 reset register", v, '0);
        end
        check1("R1 reset wb_valid", wb_valid, 1'b0);
    endtask

    task automatic t_load;
        logic [127:0] v;
        load(4'd1, v4(32'h0004_0000, 32'hFFFD_0000, 32'h0002_0000, 32'h0001_0000));
        read_reg(4'd1, v);
        check128("R2 load r1", v, v4(32'h0004_0000, 32'hFFFD_0000, 32'h0002_0000, 32'h0001_0000));
        load(4'd4, v4(32'h0005_0000, 32'h0005_0000, 32'h0005_0000, 32'h8000_0000));
        read_reg(4'd4, v);
        check128("R2 load r4", v, model[4]);
    endtask

    task automatic t_swizzle;
        logic [127:0] v;
        run_op("R3 reverse", 3'd0, 4'd2, 4'hF, 4'd1, 4'd0, 4'd0, {16'h0, SW_REV}, 3'b0, 3'b0);
        read_reg(4'd2, v);
        check128("R3 reverse literal", v, v4(32'h0001_0000, 32'h0002_0000, 32'hFFFD_0000, 32'h0004_0000));
        run_op("R3 broadcast y", 3'd0, 4'd2, 4'hF, 4'd1, 4'd0, 4'd0, {16'h0, SW_YYY}, 3'b0, 3'b0);
        read_reg(4'd2, v);
        check128("R3 broadcast literal", v, {4{32'h0002_0000}});
    endtask

    task automatic t_modifiers;
        logic [127:0] v;
        run_op("R4 abs", 3'd0, 4'd3, 4'hF, 4'd1, 4'd0, 4'd0, {16'h0, SW_ID}, 3'b000, 3'b001);
        read_reg(4'd3, v);
        check128("R4 abs literal", v, v4(32'h0004_0000, 32'h0003_0000, 32'h0002_0000, 32'h0001_0000));
        run_op("R4 abs then neg", 3'd0, 4'd3, 4'hF, 4'd1, 4'd0, 4'd0, {16'h0, SW_REV}, 3'b001, 3'b001);
        read_reg(4'd3, v);
        check128("R4 abs-neg literal", v, v4(32'hFFFF_0000, 32'hFFFE_0000, 32'hFFFD_0000, 32'hFFFC_0000));
        run_op("R4 neg only", 3'd0, 4'd3, 4'hF, 4'd1, 4'd0, 4'd0, {16'h0, SW_ID}, 3'b001, 3'b000);
        run_op("R4 abs most negative", 3'd0, 4'd3, 4'hF, 4'd4, 4'd0, 4'd0, {16'h0, SW_ID}, 3'b000, 3'b001);
        read_reg(4'd3, v);
        check128("R4 most negative literal", v, v4(32'h0005_0000, 32'h0005_0000, 32'h0005_0000, 32'h8000_0000));
    endtask

    task automatic t_add;
        logic [127:0] v;
        load(4'd6, {4{32'h7FFF_FFFF}});
        load(4'd7, {4{32'h0000_0001}});
        run_op("R5 add wrap", 3'd1, 4'd8, 4'hF, 4'd6, 4'd7, 4'd0, {8'h0, SW_ID, SW_ID}, 3'b0, 3'b0);
        read_reg(4'd8, v);
        check128("R5 wrap literal", v, {4{32'h8000_0000}});
        run_op("R5 subtract via neg", 3'd1, 4'd8, 4'hF, 4'd1, 4'd1, 4'd0, {8'h0, SW_REV, SW_ID}, 3'b010, 3'b0);
    endtask

    task automatic t_mul;
        logic [127:0] v;
        load(4'd9,  v4(32'hFFFE_8000, 32'h0000_0001, 32'hFFFF_FFFF, 32'h0001_8000));
        load(4'd10, v4(32'h0002_0000, 32'h0000_0001, 32'h0000_0001, 32'h0002_0000));
        run_op("R6 mul", 3'd2, 4'd11, 4'hF, 4'd9, 4'd10, 4'd0, {8'h0, SW_ID, SW_ID}, 3'b0, 3'b0);
        read_reg(4'd11, v);
        check128("R6 mul literal", v, v4(32'hFFFD_0000, 32'h0000_0000, 32'hFFFF_FFFF, 32'h0003_0000));
    endtask

    task automatic t_mad;
        run_op("R7 mad", 3'd3, 4'd11, 4'hF, 4'd9, 4'd10, 4'd1, {SW_ID, SW_ID, SW_ID}, 3'b0, 3'b0);
        run_op("R7 mad neg addend", 3'd3, 4'd11, 4'hF, 4'd1, 4'd1, 4'd1, {SW_REV, SW_ID, SW_ID}, 3'b100, 3'b0);
    endtask

    task automatic t_dp4;
        logic [127:0] v;
        run_op("R8 dp4 masked", 3'd4, 4'd12, 4'b0101, 4'd1, 4'd1, 4'd0, {8'h0, SW_ID, SW_ID}, 3'b0, 3'b0);
        read_reg(4'd12, v);
        check128("R8 dp4 literal", v, v4(32'h0, 32'h001E_0000, 32'h0, 32'h001E_0000));
        run_op("R8 dp4 full", 3'd4, 4'd13, 4'hF, 4'd9, 4'd10, 4'd0, {8'h0, SW_ID, SW_ID}, 3'b0, 3'b0);
    endtask

    task automatic t_cmp;
        logic [127:0] v;
        run_op("R9 cmp signs", 3'd5, 4'd13, 4'hF, 4'd1, 4'd10, 4'd9, {SW_ID, SW_ID, SW_ID}, 3'b0, 3'b0);
        read_reg(4'd13, v);
        check128("R9 cmp literal", v, v4(32'h0002_0000, 32'h0000_0001, 32'h0000_0001, 32'h0002_0000));
        run_op("R9 cmp zero lanes", 3'd5, 4'd13, 4'hF, 4'd12, 4'd1, 4'd9, {SW_ID, SW_ID, SW_ID}, 3'b0, 3'b0);
        run_op("R9 cmp most negative", 3'd5, 4'd13, 4'hF, 4'd4, 4'd1, 4'd10, {SW_ID, SW_ID, SW_ID}, 3'b0, 3'b0);
    endtask

    task automatic t_mask;
        logic [127:0] v;
        load(4'd14, {4{32'hAAAA_5555}});
        run_op("R10 mask yw", 3'd0, 4'd14, 4'b1010, 4'd1, 4'd0, 4'd0, {16'h0, SW_ID}, 3'b0, 3'b0);
        read_reg(4'd14, v);
        check128("R10 mask literal", v, v4(32'h0004_0000, 32'hAAAA_5555, 32'h0002_0000, 32'hAAAA_5555));
        run_op("R10 mask none", 3'd0, 4'd14, 4'b0000, 4'd6, 4'd0, 4'd0, {16'h0, SW_ID}, 3'b0, 3'b0);
    endtask

    task automatic t_chain;
        logic [127:0] v, first, second;
        first  = b_exec(3'd1, model[1], model[1], '0);
        second = b_exec(3'd1, first, model[1], '0);
        @(negedge clk);
        drive(3'd1, 4'd15, 4'hF, 4'd1, 4'd1, 4'd0, {8'h0, SW_ID, SW_ID}, 3'b0, 3'b0);
        @(negedge clk);
        drive(3'd1, 4'd5, 4'b0111, 4'd15, 4'd1, 4'd0, {8'h0, SW_ID, SW_ID}, 3'b0, 3'b0);
        @(negedge clk);
        issue_valid = 1'b0;
        model[15] = first;
        model[5]  = b_merge(model[5], second, 4'b0111);
        check1("R11 chain wb_valid", wb_valid, 1'b1);
        check1("R11 chain wb_dst", wb_dst == 4'd5, 1'b1);
        check1("R11 chain wb_mask", wb_mask == 4'b0111, 1'b1);
        check128("R11 chain wb_data", wb_data, second);
        read_reg(4'd5, v);
        check128("R11 dependent result", v, model[5]);
        @(negedge clk);
        check1("R11 strobe one cycle", wb_valid, 1'b0);
    endtask

    task automatic t_undef;
        run_op("R12 opcode 6", 3'd6, 4'd2, 4'hF, 4'd1, 4'd1, 4'd1, {SW_ID, SW_ID, SW_ID}, 3'b0, 3'b0);
        run_op("R12 opcode 7", 3'd7, 4'd2, 4'hF, 4'd9, 4'd9, 4'd9, {SW_ID, SW_ID, SW_ID}, 3'b0, 3'b0);
    endtask

    task automatic t_priority;
        logic [127:0] v;
        @(negedge clk);
        drive(3'd0, 4'd3, 4'hF, 4'd1, 4'd0, 4'd0, {16'h0, SW_ID}, 3'b0, 3'b0);
        ld_valid = 1'b1; ld_addr = 4'd0; ld_data = {4{32'hFFFF_FFFF}};
        @(negedge clk);
        issue_valid = 1'b0; ld_valid = 1'b0;
        model[3] = model[1];
        read_reg(4'd0, v);
        check128("R13 load dropped", v, model[0]);
        read_reg(4'd3, v);
        check128("R13 writeback kept", v, model[3]);
    endtask

    task automatic summary;
        $display("Result: errors=%0d of %0d checks", errors, checks);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        summary();
        $finish;
    end

    initial begin
        for (int r = 0; r < 16; r++) model[r] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_load();
        t_swizzle();
        t_modifiers();
        t_add();
        t_mul();
        t_mad();
        t_dp4();
        t_cmp();
        t_mask();
        t_chain();
        t_undef();
        t_priority();
        summary();
        $finish;
    end
endmodule